// File: doc/BRIEF.md
# Flash Command Engine with Interrupt Abort

This block sequences flash array operations for software: page erase, signature, mass verify and single-word program. Software loads a target byte address and a data word into registers and then writes an operation code to the command register. The engine holds the operation for a parameterised number of cycles. It drives one-cycle write or erase strobes toward the array. When the operation finishes or is cut short, it reports a two-bit outcome. Each operation has its own cycle count, and a program additionally has a short commit phase.

A running operation stops when software writes the abort code, or when a system interrupt line is raised whose bit is set in the abort-enable mask. An enabled interrupt that stays raised also kills every new command at once, until the line drops or its enable bit is cleared. A 64-bit protection map gates erase and program, one bit per 4 kB block. The map is loaded from a boot value at reset and is writable by software only when that boot value is all zeros. A level interrupt output announces each outcome when enabled, and a status read clears it.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, busy is 0, the outcome field is 2'b00, irq_out is 0, and the protection registers read back the boot value: offset 5 gives prot_boot[31:0] and offset 6 gives prot_boot[63:32].
- R2: Writing code 1 (erase), 2 (signature), 3 (verify) or 4 (program) to offset 0 while idle sets busy (status bit 0) in the following cycle. Busy stays set until the operation ends, and the outcome field (status bits [5:4] at offset 3) then reads 2'b01. A program writes the word held at offset 2 to the byte address held at offset 1. An erase sets the addressed word to all ones.
- R3: A command write other than code 7 while busy is ignored. The running operation finishes as started, and no other strobe is issued.
- R4: Writing code 7 to offset 0 while busy ends the operation in the next cycle, with busy 0 and outcome 2'b11.
- R5: While busy, an interrupt line irq_in[n] that is high while bit n of the abort-enable mask (offset 4) is set ends the operation in the next cycle with outcome 2'b11. A raised line whose enable bit is clear has no effect.
- R6: While an enabled interrupt stays high, every new command ends at once with busy 0 and outcome 2'b11, and it does not touch the array. Once the enable bit is cleared, commands run normally again.
- R7: An abort before the commit phase of a program leaves the target word unchanged. An abort during the commit phase lets the word be written, and the outcome still reads 2'b11.
- R8: An erase or program aimed at a block whose protection bit is 1 ends at once with outcome 2'b10 and produces no strobe. The block is byte-address bits [17:12], and block b uses bit b of {offset 6, offset 5}. Signature and verify are not gated by protection.
- R9: The protection registers accept software writes only when prot_boot is zero. Otherwise they ignore writes.
- R10: When bit 0 of offset 7 is set, irq_out rises after any outcome is posted. A read of offset 3 clears it. With that bit clear, irq_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the pending interrupt on offset 3) |
| reg_addr | input | 3 | Register offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for reg_addr |
| irq_in | input | IRQ_W | System interrupt lines |
| prot_boot | input | 64 | Stored protection value loaded at reset |
| fl_addr | output | FA_W | Latched target byte address |
| fl_wdata | output | 32 | Latched program data |
| fl_we | output | 1 | One-cycle array word write strobe |
| fl_erase | output | 1 | One-cycle array block erase strobe |
| irq_out | output | 1 | Level completion/abort interrupt |

## Verification
On every cycle, the assertions check the control responses that settle within one clock. These are the abort code, an enabled interrupt during an operation, an instant abort of a new command under a held interrupt, the refusal of a command aimed at a protected block, and the clearing of irq_out by a status read. They also check that no write strobe appears outside an operation and that the two strobes never coincide. Only the bench scenarios can show what reaches the array model. That covers whether an aborted program left its word intact or committed it, whether an ignored command really left the array alone, the erase contents, and the locking of the protection map by a nonzero boot value.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int NBLK   = 64;
  localparam int NWORD  = NBLK / 32;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_DATA = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_AEN  = 3'd4;
  localparam logic [2:0] RA_PLO  = 3'd5;
  localparam logic [2:0] RA_PHI  = 3'd6;
  localparam logic [2:0] RA_IEN  = 3'd7;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ERASE  = 3'd1,
    OP_SIGN   = 3'd2,
    OP_VERIFY = 3'd3,
    OP_PROG   = 3'd4,
    OP_ABORT  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_OK    = 2'b01,
    RES_PROT  = 2'b10,
    RES_ABORT = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_COMMIT = 2'd2
  } st_e;
endpackage

// File: rtl/flash_abort_mon.sv
module flash_abort_mon #(
  parameter int IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] irq,
  input  logic [IRQ_W-1:0] mask,
  output logic             hit
);
  logic [IRQ_W-1:0] armed;

  always_comb begin
    armed = irq & mask;
    hit   = |armed;
  end
endmodule

// File: rtl/flash_prot_map.sv
module flash_prot_map
  import flash_cmd_pkg::*;
#(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBLK-1:0]  boot,
  input  logic [NWORD-1:0] wr_word,
  input  logic [31:0]      wdata,
  input  logic [BLK_W-1:0] blk_idx,
  output logic [NBLK-1:0]  prot_vec,
  output logic             blk_prot
);
  logic        unlocked;
  logic [31:0] word_q [NWORD];
  logic [31:0] word_d [NWORD];

  assign unlocked = (boot == '0);

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    always_comb begin
      word_d[g] = word_q[g];
      if (wr_word[g] && unlocked) word_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[g] <= boot[g*32 +: 32];
      else        word_q[g] <= word_d[g];
    end

    assign prot_vec[g*32 +: 32] = word_q[g];
  end

  assign blk_prot = prot_vec[blk_idx];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int FA_W       = 18,
  parameter int ERASE_CYC  = 12,
  parameter int SIGN_CYC   = 6,
  parameter int VERIFY_CYC = 10,
  parameter int PROG_CYC   = 8,
  parameter int COMMIT_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  op_e             start_op,
  input  logic            blk_prot,
  input  logic            sw_abort,
  input  logic            irq_hit,
  input  logic [FA_W-1:0] addr_in,
  input  logic [31:0]     data_in,
  output logic            busy,
  output res_e            result,
  output logic            evt,
  output op_e             cur_op,
  output logic [FA_W-1:0] fl_addr,
  output logic [31:0]     fl_wdata,
  output logic            fl_we,
  output logic            fl_erase
);
  localparam int MAX_A = (ERASE_CYC > SIGN_CYC) ? ERASE_CYC : SIGN_CYC;
  localparam int MAX_B = (VERIFY_CYC > PROG_CYC) ? VERIFY_CYC : PROG_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAXD  = (MAX_C > COMMIT_CYC) ? MAX_C : COMMIT_CYC;
  localparam int CNT_W = $clog2(MAXD + 1);

  st_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_e             op_q, op_d;
  res_e            res_q, res_d;
  logic [FA_W-1:0] adr_q, adr_d;
  logic [31:0]     dat_q, dat_d;
  logic            we_q, we_d, er_q, er_d;
  logic            evt_d;
  logic            kill;

  function automatic logic [CNT_W-1:0] dur_of(op_e op);
    case (op)
      OP_ERASE:  dur_of = CNT_W'(ERASE_CYC - 1);
      OP_SIGN:   dur_of = CNT_W'(SIGN_CYC - 1);
      OP_VERIFY: dur_of = CNT_W'(VERIFY_CYC - 1);
      default:   dur_of = CNT_W'(PROG_CYC - 1);
    endcase
  endfunction

  assign kill = sw_abort || irq_hit;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    op_d  = op_q;
    res_d = res_q;
    adr_d = adr_q;
    dat_d = dat_q;
    we_d  = 1'b0;
    er_d  = 1'b0;
    evt_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          evt_d = 1'b1;
          if (irq_hit) begin
            res_d = RES_ABORT;
          end else if ((start_op == OP_ERASE || start_op == OP_PROG) && blk_prot) begin
            res_d = RES_PROT;
          end else begin
            evt_d = 1'b0;
            st_d  = ST_RUN;
            op_d  = start_op;
            cnt_d = dur_of(start_op);
            res_d = RES_NONE;
            adr_d = addr_in;
            dat_d = data_in;
          end
        end
      end
      ST_RUN: begin
        if (kill) begin
          st_d  = ST_IDLE;
          res_d = RES_ABORT;
          evt_d = 1'b1;
        end else if (cnt_q == '0) begin
          if (op_q == OP_PROG) begin
            st_d  = ST_COMMIT;
            cnt_d = CNT_W'(COMMIT_CYC - 1);
            we_d  = 1'b1;
          end else begin
            st_d  = ST_IDLE;
            res_d = RES_OK;
            evt_d = 1'b1;
            er_d  = (op_q == OP_ERASE);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_COMMIT: begin
        if (kill) begin
          st_d  = ST_IDLE;
          res_d = RES_ABORT;
          evt_d = 1'b1;
        end else if (cnt_q == '0) begin
          st_d  = ST_IDLE;
          res_d = RES_OK;
          evt_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      op_q  <= OP_NONE;
      res_q <= RES_NONE;
      adr_q <= '0;
      dat_q <= '0;
      we_q  <= 1'b0;
      er_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      op_q  <= op_d;
      res_q <= res_d;
      adr_q <= adr_d;
      dat_q <= dat_d;
      we_q  <= we_d;
      er_q  <= er_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign result   = res_q;
  assign evt      = evt_d;
  assign cur_op   = op_q;
  assign fl_addr  = adr_q;
  assign fl_wdata = dat_q;
  assign fl_we    = we_q;
  assign fl_erase = er_q;
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int IRQ_W      = 8,
  parameter int FA_W       = 18,
  parameter int BLK_SHIFT  = 12,
  parameter int ERASE_CYC  = 12,
  parameter int SIGN_CYC   = 6,
  parameter int VERIFY_CYC = 10,
  parameter int PROG_CYC   = 8,
  parameter int COMMIT_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic [63:0]      prot_boot,
  output logic [FA_W-1:0]  fl_addr,
  output logic [31:0]      fl_wdata,
  output logic             fl_we,
  output logic             fl_erase,
  output logic             irq_out
);
  localparam int BLK_W = FA_W - BLK_SHIFT;

  logic [FA_W-1:0]  addr_q, addr_d;
  logic [31:0]      data_q, data_d;
  logic [IRQ_W-1:0] aen_q, aen_d;
  logic             ien_q, ien_d;
  logic             pend_q, pend_d;

  logic             cmd_wr, start, sw_abort, irq_hit, blk_prot, busy, evt, stat_rd;
  logic [NWORD-1:0] prot_wr;
  logic [NBLK-1:0]  prot_vec;
  op_e              wr_op, cur_op;
  res_e             result;

  assign cmd_wr   = wr_en && (reg_addr == RA_CMD);
  assign wr_op    = op_e'(wdata[2:0]);
  assign start    = cmd_wr && !busy &&
                    (wr_op == OP_ERASE || wr_op == OP_SIGN ||
                     wr_op == OP_VERIFY || wr_op == OP_PROG);
  assign sw_abort = cmd_wr && busy && (wr_op == OP_ABORT);
  assign stat_rd  = rd_en && (reg_addr == RA_STAT);
  assign prot_wr  = {wr_en && (reg_addr == RA_PHI), wr_en && (reg_addr == RA_PLO)};

  flash_abort_mon #(.IRQ_W(IRQ_W)) u_abort (
    .irq  (irq_in),
    .mask (aen_q),
    .hit  (irq_hit)
  );

  flash_prot_map #(.BLK_W(BLK_W)) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot     (prot_boot),
    .wr_word  (prot_wr),
    .wdata    (wdata),
    .blk_idx  (addr_q[BLK_SHIFT +: BLK_W]),
    .prot_vec (prot_vec),
    .blk_prot (blk_prot)
  );

  flash_cmd_seq #(
    .FA_W(FA_W), .ERASE_CYC(ERASE_CYC), .SIGN_CYC(SIGN_CYC),
    .VERIFY_CYC(VERIFY_CYC), .PROG_CYC(PROG_CYC), .COMMIT_CYC(COMMIT_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_op (wr_op),
    .blk_prot (blk_prot),
    .sw_abort (sw_abort),
    .irq_hit  (irq_hit),
    .addr_in  (addr_q),
    .data_in  (data_q),
    .busy     (busy),
    .result   (result),
    .evt      (evt),
    .cur_op   (cur_op),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we    (fl_we),
    .fl_erase (fl_erase)
  );

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    aen_d  = aen_q;
    ien_d  = ien_q;
    pend_d = pend_q;
    if (wr_en) begin
      case (reg_addr)
        RA_ADDR: addr_d = wdata[FA_W-1:0];
        RA_DATA: data_d = wdata;
        RA_AEN:  aen_d  = wdata[IRQ_W-1:0];
        RA_IEN:  ien_d  = wdata[0];
        default: ;
      endcase
    end
    if (evt)          pend_d = 1'b1;
    else if (stat_rd) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      aen_q  <= '0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      aen_q  <= aen_d;
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr)
      RA_ADDR: rdata[FA_W-1:0]  = addr_q;
      RA_DATA: rdata            = data_q;
      RA_STAT: rdata            = {23'd0, pend_q, 2'b00, result, 3'b000, busy};
      RA_AEN:  rdata[IRQ_W-1:0] = aen_q;
      RA_PLO:  rdata            = prot_vec[31:0];
      RA_PHI:  rdata            = prot_vec[63:32];
      RA_IEN:  rdata[0]         = ien_q;
      default: rdata            = '0;
    endcase
  end

  assign irq_out = pend_q && ien_q;
endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [2:0]  reg_addr,
  input logic [31:0] wdata,
  input logic        busy,
  input logic [1:0]  result,
  input logic        irq_hit,
  input logic        blk_prot,
  input logic [2:0]  cur_op,
  input logic        fl_we,
  input logic        fl_erase,
  input logic        irq_out
);
  logic cmdw, is_abort, is_op, is_gated;
  assign cmdw     = wr_en && (reg_addr == 3'd0);
  assign is_abort = (wdata[2:0] == 3'd7);
  assign is_op    = (wdata[2:0] >= 3'd1) && (wdata[2:0] <= 3'd4);
  assign is_gated = (wdata[2:0] == 3'd1) || (wdata[2:0] == 3'd4);

  // R4
  sw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdw && is_abort && busy) |=> (!busy && result == 2'b11));

  // R5
  irq_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_hit) |=> (!busy && result == 2'b11));

  // R6
  sticky_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdw && is_op && !busy && irq_hit) |=> (!busy && result == 2'b11));

  // R8
  prot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdw && is_gated && !busy && !irq_hit && blk_prot) |=> (!busy && result == 2'b10));

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmdw && !is_abort) |=> $stable(cur_op));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == 3'd3 && !busy && !wr_en) |=> !irq_out);

  // R2
  we_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> busy);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_we, fl_erase}));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .reg_addr (reg_addr),
  .wdata    (wdata),
  .busy     (busy),
  .result   (result),
  .irq_hit  (irq_hit),
  .blk_prot (blk_prot),
  .cur_op   (cur_op),
  .fl_we    (fl_we),
  .fl_erase (fl_erase),
  .irq_out  (irq_out)
);

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [7:0]  irq_in = 8'd0;
  logic [63:0] prot_boot = 64'd0;
  logic [17:0] fl_addr;
  logic [31:0] fl_wdata;
  logic        fl_we, fl_erase, irq_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] mem [0:63];

  always #4 clk = ~clk;

  flash_cmd_engine u_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata),
    .irq_in(irq_in), .prot_boot(prot_boot),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_erase(fl_erase), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    if (fl_we)    mem[fl_addr[17:12]] <= fl_wdata;
    if (fl_erase) mem[fl_addr[17:12]] <= 32'hFFFF_FFFF;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [63:0] boot);
    prot_boot = boot;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = rdata;
  endtask

  task automatic stat_read(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_addr = 3'd3;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      peek(3'd3, s);
      if (!s[0]) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset(64'd0);
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b00, "R1 status", v, 32'h0);
    check(irq_out == 1'b0, "R1 irq_out", {31'd0, irq_out}, 32'h0);
    peek(3'd5, v);
    check(v == 32'h0, "R1 prot lo", v, 32'h0);
  endtask

  task automatic t_program();
    logic [31:0] v;
    bus_write(3'd7, 32'd1);
    bus_write(3'd1, 32'h5 << 12);
    bus_write(3'd2, 32'h1234_5678);
    bus_write(3'd0, 32'd4);
    peek(3'd3, v);
    check(v[0] == 1'b1, "R2 busy after start", v, 32'h1);
    wait_idle();
    peek(3'd3, v);
    check(v[5:4] == 2'b01, "R2 program outcome", {30'd0, v[5:4]}, 32'h1);
    check(mem[5] == 32'h1234_5678, "R2 program data", mem[5], 32'h1234_5678);
    check(irq_out == 1'b1, "R10 irq raised", {31'd0, irq_out}, 32'h1);
    stat_read(v);
    check(irq_out == 1'b0, "R10 irq cleared by read", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    bus_write(3'd1, 32'h6 << 12);
    bus_write(3'd0, 32'd1);
    wait_idle();
    @(negedge clk);
    peek(3'd3, v);
    check(v[5:4] == 2'b01, "R2 erase outcome", {30'd0, v[5:4]}, 32'h1);
    check(mem[6] == 32'hFFFF_FFFF, "R2 erase contents", mem[6], 32'hFFFF_FFFF);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    bus_write(3'd1, 32'h7 << 12);
    bus_write(3'd2, 32'hCAFE_0007);
    bus_write(3'd0, 32'd4);
    bus_write(3'd0, 32'd1);
    wait_idle();
    repeat (4) @(negedge clk);
    peek(3'd3, v);
    check(v[5:4] == 2'b01, "R3 op finished", {30'd0, v[5:4]}, 32'h1);
    check(mem[7] == 32'hCAFE_0007, "R3 no erase while busy", mem[7], 32'hCAFE_0007);
  endtask

  task automatic t_sw_abort();
    logic [31:0] v;
    logic [31:0] old;
    old = mem[8];
    bus_write(3'd1, 32'h8 << 12);
    bus_write(3'd2, 32'h0BAD_0008);
    bus_write(3'd0, 32'd4);
    repeat (2) @(negedge clk);
    bus_write(3'd0, 32'd7);
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b11, "R4 sw abort", v, 32'h30);
    repeat (12) @(negedge clk);
    check(mem[8] == old, "R7 early abort keeps word", mem[8], old);
  endtask

  task automatic t_commit_abort();
    logic [31:0] v;
    bus_write(3'd1, 32'h9 << 12);
    bus_write(3'd2, 32'h600D_0009);
    bus_write(3'd0, 32'd4);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (fl_we) break;
    end
    wr_en = 1'b1; reg_addr = 3'd0; wdata = 32'd7;
    @(negedge clk);
    wr_en = 1'b0;
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b11, "R7 commit abort status", v, 32'h30);
    check(mem[9] == 32'h600D_0009, "R7 commit abort word written", mem[9], 32'h600D_0009);
  endtask

  task automatic t_irq_abort();
    logic [31:0] v;
    bus_write(3'd4, 32'h04);
    bus_write(3'd0, 32'd2);
    irq_in = 8'h02;
    repeat (2) @(negedge clk);
    peek(3'd3, v);
    check(v[0] == 1'b1, "R5 masked irq ignored", v, 32'h1);
    irq_in = 8'h06;
    @(negedge clk);
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b11, "R5 enabled irq aborts", v, 32'h30);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    logic [31:0] old;
    old = mem[10];
    bus_write(3'd0, 32'd3);
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b11, "R6 verify killed", v, 32'h30);
    bus_write(3'd1, 32'hA << 12);
    bus_write(3'd0, 32'd4);
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b11, "R6 program killed", v, 32'h30);
    repeat (12) @(negedge clk);
    check(mem[10] == old, "R6 array untouched", mem[10], old);
    bus_write(3'd4, 32'h00);
    bus_write(3'd0, 32'd3);
    wait_idle();
    peek(3'd3, v);
    check(v[5:4] == 2'b01, "R6 runs after enable cleared", {30'd0, v[5:4]}, 32'h1);
    irq_in = 8'h00;
  endtask

  task automatic t_protect();
    logic [31:0] v;
    logic [31:0] old;
    bus_write(3'd5, 32'h8);
    peek(3'd5, v);
    check(v == 32'h8, "R9 unlocked write", v, 32'h8);
    old = mem[3];
    bus_write(3'd1, 32'h3 << 12);
    bus_write(3'd0, 32'd1);
    peek(3'd3, v);
    check(v[0] == 1'b0 && v[5:4] == 2'b10, "R8 erase refused", v, 32'h20);
    repeat (14) @(negedge clk);
    check(mem[3] == old, "R8 protected block intact", mem[3], old);
    bus_write(3'd0, 32'd2);
    wait_idle();
    peek(3'd3, v);
    check(v[5:4] == 2'b01, "R8 sign not gated", {30'd0, v[5:4]}, 32'h1);
    bus_write(3'd6, 32'h1);
    bus_write(3'd1, 32'd32 << 12);
    bus_write(3'd0, 32'd4);
    peek(3'd3, v);
    check(v[5:4] == 2'b10, "R8 high word protects block 32", {30'd0, v[5:4]}, 32'h2);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    do_reset(64'h0000_0001_0000_0010);
    peek(3'd5, v);
    check(v == 32'h10, "R1 boot lo", v, 32'h10);
    peek(3'd6, v);
    check(v == 32'h1, "R1 boot hi", v, 32'h1);
    bus_write(3'd5, 32'h0);
    peek(3'd5, v);
    check(v == 32'h10, "R9 locked write ignored", v, 32'h10);
    bus_write(3'd1, 32'h4 << 12);
    bus_write(3'd0, 32'd4);
    peek(3'd3, v);
    check(v[5:4] == 2'b10, "R9 boot protection active", {30'd0, v[5:4]}, 32'h2);
  endtask

  task automatic t_irq_off();
    bus_write(3'd7, 32'd0);
    bus_write(3'd0, 32'd2);
    wait_idle();
    @(negedge clk);
    check(irq_out == 1'b0, "R10 irq disabled", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5_0000 + i;
    t_reset();
    t_program();
    t_erase();
    t_ignore();
    t_sw_abort();
    t_commit_abort();
    t_irq_abort();
    t_sticky();
    t_protect();
    t_locked();
    t_irq_off();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule